// File: doc/BRIEF.md
# Maskable Temperature Interrupt Controller

This block turns a stream of temperature conversion results into an active-low interrupt line. Each result carries a sensor index and a signed 8-bit reading in two's complement. For each sensor the block stores an upper and a lower limit. A reading above the upper limit, or below the lower one, on three back-to-back conversions of that sensor qualifies as a violation. A qualified violation sets a status bit, a matching mirror bit and a pending-interrupt bit. The interrupt line follows the pending bits that the mask register does not block. An external active-low fail-safe input also pulls the line low.

The block keeps one "already reported" flag per sensor per limit, so a condition that persists raises the interrupt only once. The flag re-arms when a reading returns inside that limit or when software rewrites that limit. The streak count survives a limit rewrite. If the temperature is still outside the new limit on the next conversion, the interrupt is raised again. Software reads and writes the registers through a simple single-cycle register port. Reading the status register or the mirror register clears only the register that was read.

Conversion input handshake: `conv_ready` is held high, so the block never applies back-pressure. A result is consumed on every rising clock edge where `conv_valid` is high. Register read data is combinational from `reg_addr`. The clear side effect of a read takes place at the clock edge where `reg_rd` is high.

Top module: `tic_int_ctrl`

## Requirements
- R1: For sensor k, status bit 2k (upper limit) sets only on the third and later consecutive conversion of sensor k with reading > upper limit (signed). Status bit 2k+1 (lower limit) follows the same rule for reading < lower limit. Conversions of other sensors do not break the streak.
- R2: A set bit in the mask register (address 1, same bit layout as status) keeps that source from pulling `irq_n` low, but the status bit still sets.
- R3: A read of address 0 returns the status register, and the status register is zero after that edge (subject to R9).
- R4: Writing a 1 to bit 2 of the control register (address 3) clears all pending interrupt bits, so `irq_n` goes high if the fail-safe input is high. Status and mirror registers keep their values.
- R5: After a source has been reported, further violating conversions of the same limit do not set its bit again. The flag re-arms once a reading of that sensor falls inside that limit.
- R6: `irq_n` falls again when the other limit of the same sensor qualifies, or when another sensor qualifies. It also falls when a reported limit is rewritten and the next conversion of that sensor is still outside the new value after a streak of at least three.
- R7: While `failsafe_n` is low, `irq_n` is low.
- R8: The mirror register (address 2) sets each bit together with the matching status bit. Only a read of address 2 clears it, and it never drives `irq_n`.
- R9: If a clearing read or a clear command falls in the same cycle as a new qualified violation, the new bit is kept.
- R10: After reset, status, mirror, mask and pending bits are zero, and `irq_n` equals `failsafe_n`. Upper limits read 70 and lower limits read -128 (0x80). `conv_ready` is always 1.
- R11: The upper limit of sensor k is at address 4+2k and the lower limit of sensor k is at address 5+2k, both read/write. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | Conversion result present |
| conv_ready | output | 1 | Always 1; result accepted whenever valid |
| conv_sensor | input | 2 | Sensor index of the result |
| conv_temp | input | 8 | Signed reading, two's complement |
| failsafe_n | input | 1 | Active-low thermal fail-safe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The embedded properties check on every cycle that a reported limit cannot fire twice in a row and that a new violation survives a same-cycle clearing read. They also check that a status read empties the register when nothing new arrives and that the clear command leaves status untouched while releasing the line. Finally, they check that the mirror only loses bits through its own read. The three-conversion streak, re-arming after an in-limit reading, re-assertion after a limit rewrite, masking and the fail-safe override can only be shown by the bench's scenarios. In those scenarios, directed sequences and a long randomized run are compared with a reference model written from the requirements.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int ADR_STATUS   = 0;
  localparam int ADR_MASK     = 1;
  localparam int ADR_MIRROR   = 2;
  localparam int ADR_CTRL     = 3;
  localparam int ADR_LIM_BASE = 4;
  localparam int CTRL_CLR_BIT = 2;
  localparam int LIM_UP       = 0;
  localparam int LIM_DN       = 1;
endpackage

// File: rtl/tic_sensor_chan.sv
module tic_sensor_chan #(
  parameter int TW     = 8,
  parameter int CONSEC = 3,
  parameter int UP_RST = 70,
  parameter int DN_RST = -128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_hit,
  input  logic [TW-1:0] conv_temp,
  input  logic          wr_up,
  input  logic          wr_dn,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] lim_up,
  output logic [TW-1:0] lim_dn,
  output logic          ev_up,
  output logic          ev_dn
);
  import tic_pkg::*;

  localparam int CW = $clog2(CONSEC + 1);

  logic [TW-1:0] lim  [2];
  logic          wr   [2];
  logic          viol [2];
  logic          ev   [2];
  logic [CW-1:0] cnt  [2];
  logic          rep  [2];

  assign wr[LIM_UP]   = wr_up;
  assign wr[LIM_DN]   = wr_dn;
  assign viol[LIM_UP] = $signed(conv_temp) > $signed(lim[LIM_UP]);
  assign viol[LIM_DN] = $signed(conv_temp) < $signed(lim[LIM_DN]);
  assign lim_up       = lim[LIM_UP];
  assign lim_dn       = lim[LIM_DN];
  assign ev_up        = ev[LIM_UP];
  assign ev_dn        = ev[LIM_DN];

  for (genvar j = 0; j < 2; j++) begin : g_lim
    localparam logic [TW-1:0] RST_VAL = (j == LIM_UP) ? TW'(UP_RST) : TW'(DN_RST);

    assign ev[j] = conv_hit && viol[j] && (int'(cnt[j]) >= CONSEC - 1) && !rep[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim[j] <= RST_VAL;
      end else if (wr[j]) begin
        lim[j] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[j] <= '0;
      end else if (conv_hit) begin
        if (!viol[j])                 cnt[j] <= '0;
        else if (int'(cnt[j]) < CONSEC) cnt[j] <= cnt[j] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rep[j] <= 1'b0;
      end else if (ev[j]) begin
        rep[j] <= 1'b1;
      end else if ((conv_hit && !viol[j]) || wr[j]) begin
        rep[j] <= 1'b0;
      end
    end

    AST_REPORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      ev[j] |=> !ev[j]); // R5
  end

endmodule

// File: rtl/tic_status_bank.sv
module tic_status_bank #(
  parameter int SB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SB-1:0] ev,
  input  logic          mask_wr,
  input  logic [SB-1:0] mask_d,
  input  logic          rd_status,
  input  logic          rd_mirror,
  input  logic          irq_clr,
  input  logic          failsafe_n,
  output logic [SB-1:0] status,
  output logic [SB-1:0] mirror,
  output logic [SB-1:0] mask,
  output logic          irq_n
);
  logic [SB-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      mirror  <= '0;
      pending <= '0;
      mask    <= '0;
    end else begin
      status  <= (rd_status ? '0 : status)  | ev;
      mirror  <= (rd_mirror ? '0 : mirror)  | ev;
      pending <= (irq_clr   ? '0 : pending) | ev;
      if (mask_wr) mask <= mask_d;
    end
  end

  assign irq_n = failsafe_n && ((pending & ~mask) == '0);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status || irq_clr) |=> ((status & $past(ev)) == $past(ev))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && ev == '0) |=> (status == '0)); // R3
  AST_CLR_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !rd_status) |=> (status == ($past(status) | $past(ev)))); // R4
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && ev == '0) |=> (irq_n == failsafe_n)); // R4
  AST_MIRROR_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mirror |=> ((mirror & $past(mirror)) == $past(mirror))); // R8

endmodule

// File: rtl/tic_int_ctrl.sv
module tic_int_ctrl #(
  parameter int NUM_SENS = 3,
  parameter int TW       = 8,
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int CONSEC   = 3,
  parameter int UP_RST   = 70,
  parameter int DN_RST   = -128,
  parameter int SW       = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  output logic          conv_ready,
  input  logic [SW-1:0] conv_sensor,
  input  logic [TW-1:0] conv_temp,
  input  logic          failsafe_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  import tic_pkg::*;

  localparam int SB = 2 * NUM_SENS;

  logic          accept;
  logic [SB-1:0] ev;
  logic [SB-1:0] status, mirror, mask;
  logic [TW-1:0] lim_up [NUM_SENS];
  logic [TW-1:0] lim_dn [NUM_SENS];

  assign conv_ready = 1'b1;
  assign accept     = conv_valid && conv_ready;

  for (genvar k = 0; k < NUM_SENS; k++) begin : g_sens
    logic hit, wr_up, wr_dn, e_up, e_dn;
    assign hit   = accept && (conv_sensor == SW'(k));
    assign wr_up = reg_wr && (reg_addr == AW'(ADR_LIM_BASE + 2 * k));
    assign wr_dn = reg_wr && (reg_addr == AW'(ADR_LIM_BASE + 2 * k + 1));

    tic_sensor_chan #(
      .TW(TW), .CONSEC(CONSEC), .UP_RST(UP_RST), .DN_RST(DN_RST)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_hit  (hit),
      .conv_temp (conv_temp),
      .wr_up     (wr_up),
      .wr_dn     (wr_dn),
      .wdata     (reg_wdata[TW-1:0]),
      .lim_up    (lim_up[k]),
      .lim_dn    (lim_dn[k]),
      .ev_up     (e_up),
      .ev_dn     (e_dn)
    );

    assign ev[2*k]   = e_up;
    assign ev[2*k+1] = e_dn;
  end

  tic_status_bank #(.SB(SB)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .mask_wr    (reg_wr && (reg_addr == AW'(ADR_MASK))),
    .mask_d     (reg_wdata[SB-1:0]),
    .rd_status  (reg_rd && (reg_addr == AW'(ADR_STATUS))),
    .rd_mirror  (reg_rd && (reg_addr == AW'(ADR_MIRROR))),
    .irq_clr    (reg_wr && (reg_addr == AW'(ADR_CTRL)) && reg_wdata[CTRL_CLR_BIT]),
    .failsafe_n (failsafe_n),
    .status     (status),
    .mirror     (mirror),
    .mask       (mask),
    .irq_n      (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADR_STATUS)) reg_rdata = DW'(status);
    if (reg_addr == AW'(ADR_MASK))   reg_rdata = DW'(mask);
    if (reg_addr == AW'(ADR_MIRROR)) reg_rdata = DW'(mirror);
    for (int k = 0; k < NUM_SENS; k++) begin
      if (reg_addr == AW'(ADR_LIM_BASE + 2 * k))     reg_rdata = DW'(lim_up[k]);
      if (reg_addr == AW'(ADR_LIM_BASE + 2 * k + 1)) reg_rdata = DW'(lim_dn[k]);
    end
  end

endmodule

// File: tb/tb_tic_int_ctrl.sv
module tb_tic_int_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_valid = 1'b0;
  logic       conv_ready;
  logic [1:0] conv_sensor = '0;
  logic [7:0] conv_temp = '0;
  logic       failsafe_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] last_rd;

  int         m_up [NS];
  int         m_dn [NS];
  int         m_cnt[NS][2];
  bit         m_rep[NS][2];
  logic [7:0] m_status, m_mirror, m_pend, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  tic_int_ctrl dut (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_sensor(conv_sensor), .conv_temp(conv_temp), .failsafe_n(failsafe_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(logic [3:0] a);
    logic [7:0] r = 8'h00;
    case (a)
      4'd0: r = m_status;
      4'd1: r = m_mask;
      4'd2: r = m_mirror;
      default: begin
        for (int k = 0; k < NS; k++) begin
          if (int'(a) == 4 + 2*k) r = 8'(m_up[k]);
          if (int'(a) == 5 + 2*k) r = 8'(m_dn[k]);
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic exp_irq_n();
    return failsafe_n && ((m_pend & ~m_mask) == 8'h00);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NS; k++) begin
      m_up[k] = 70; m_dn[k] = -128;
      for (int j = 0; j < 2; j++) begin m_cnt[k][j] = 0; m_rep[k][j] = 0; end
    end
    m_status = 0; m_mirror = 0; m_pend = 0; m_mask = 0;
  endtask

  task automatic model_edge();
    logic [7:0] evs = 8'h00;
    int t = int'($signed(conv_temp));
    for (int k = 0; k < NS; k++) begin
      bit hit = conv_valid && (int'(conv_sensor) == k);
      for (int j = 0; j < 2; j++) begin
        bit v = (j == 0) ? (t > m_up[k]) : (t < m_dn[k]);
        bit w = reg_wr && (int'(reg_addr) == 4 + 2*k + j);
        bit e = hit && v && (m_cnt[k][j] >= 2) && !m_rep[k][j];
        if (e) evs[2*k+j] = 1'b1;
        if (hit) m_cnt[k][j] = v ? ((m_cnt[k][j] < 3) ? m_cnt[k][j] + 1 : 3) : 0;
        if (e) m_rep[k][j] = 1;
        else if ((hit && !v) || w) m_rep[k][j] = 0;
        if (w) begin
          if (j == 0) m_up[k] = int'($signed(reg_wdata));
          else        m_dn[k] = int'($signed(reg_wdata));
        end
      end
    end
    m_status = ((reg_rd && reg_addr == 0) ? 8'h00 : m_status) | evs;
    m_mirror = ((reg_rd && reg_addr == 2) ? 8'h00 : m_mirror) | evs;
    m_pend   = ((reg_wr && reg_addr == 3 && reg_wdata[2]) ? 8'h00 : m_pend) | evs;
    if (reg_wr && reg_addr == 1) m_mask = {2'b00, reg_wdata[5:0]};
  endtask

  // Inputs are driven at a falling edge before calling cyc.
  task automatic cyc(string tag);
    #1;
    last_rd = reg_rdata;
    if (reg_rd) chk({tag, " rdata"}, reg_rdata, exp_rdata(reg_addr));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    conv_valid = 0; reg_wr = 0; reg_rd = 0;
    chk({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, exp_irq_n()});
  endtask

  task automatic conv(int id, int t, string tag);
    conv_valid = 1; conv_sensor = 2'(id); conv_temp = 8'(t);
    cyc(tag);
  endtask

  task automatic wr(int a, int d, string tag);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    cyc(tag);
  endtask

  task automatic rd(int a, string tag);
    reg_rd = 1; reg_addr = 4'(a);
    cyc(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq_n", {7'd0, irq_n}, 8'd1);
    chk("R10 conv_ready", {7'd0, conv_ready}, 8'd1);
    rd(0, "R10"); chk("R10 status", last_rd, 8'h00);
    rd(4, "R11"); chk("R11 up0", last_rd, 8'd70);
    rd(9, "R11"); chk("R11 dn2", last_rd, 8'h80);
    rd(12, "R11"); chk("R11 unused", last_rd, 8'h00);

    // R1 streak of three
    wr(4, 50, "R11");
    conv(0, 60, "R1"); conv(1, 99, "R1"); conv(0, 60, "R1");
    chk("R1 two", {7'd0, irq_n}, 8'd1);
    conv(0, 60, "R1");
    chk("R1 third", {7'd0, irq_n}, 8'd0);
    wr(3, 8'h04, "R4");
    chk("R4 release", {7'd0, irq_n}, 8'd1);
    rd(0, "R3"); chk("R3 value", last_rd, 8'h01);
    rd(0, "R3"); chk("R3 cleared", last_rd, 8'h00);
    rd(2, "R8"); chk("R8 mirror kept", last_rd, 8'h01);
    rd(2, "R8"); chk("R8 mirror cleared", last_rd, 8'h00);

    // R5 no repeat while beyond same limit
    conv(0, 60, "R5"); conv(0, 61, "R5");
    chk("R5 quiet", {7'd0, irq_n}, 8'd1);
    // R6 other limit of same sensor
    wr(5, 20, "R11");
    conv(0, 10, "R6"); conv(0, 10, "R6"); conv(0, 10, "R6");
    chk("R6 other limit", {7'd0, irq_n}, 8'd0);
    wr(3, 8'h04, "R4");
    // R5 re-arm after inside reading
    conv(0, 60, "R5"); conv(0, 60, "R5"); conv(0, 60, "R5");
    chk("R5 rearmed", {7'd0, irq_n}, 8'd0);
    wr(3, 8'h04, "R4");
    // R6 rewrite of violated limit
    wr(4, 58, "R6");
    conv(0, 60, "R6");
    chk("R6 rewrite", {7'd0, irq_n}, 8'd0);
    wr(3, 8'h04, "R4");
    rd(0, "R3");

    // R2 mask
    wr(1, 8'h04, "R2");
    wr(6, 30, "R11");
    conv(1, 40, "R2"); conv(1, 40, "R2"); conv(1, 40, "R2");
    chk("R2 masked", {7'd0, irq_n}, 8'd1);
    rd(0, "R2"); chk("R2 status", last_rd & 8'h04, 8'h04);
    // R6 another source
    wr(8, 30, "R11");
    conv(2, 40, "R6"); conv(2, 40, "R6"); conv(2, 40, "R6");
    chk("R6 other source", {7'd0, irq_n}, 8'd0);
    wr(3, 8'h04, "R4");
    // R7 fail-safe
    failsafe_n = 0; rd(1, "R7");
    chk("R7 low", {7'd0, irq_n}, 8'd0);
    failsafe_n = 1; rd(1, "R7");
    chk("R7 high", {7'd0, irq_n}, 8'd1);
    // R9 set beats clearing read
    wr(9, 20, "R11");
    conv(2, 10, "R9"); conv(2, 10, "R9");
    conv_valid = 1; conv_sensor = 2; conv_temp = 8'd10;
    reg_rd = 1; reg_addr = 0;
    cyc("R9");
    rd(0, "R9"); chk("R9 kept", last_rd & 8'h20, 8'h20);
    rd(2, "R8"); chk("R8 mirror bit5", last_rd & 8'h20, 8'h20);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom_range(0, 99));
      if ($urandom_range(0, 99) < 3) failsafe_n = ~failsafe_n;
      if (op < 50) begin
        conv_valid = 1; conv_sensor = 2'($urandom_range(0, NS-1));
        conv_temp = 8'($urandom_range(0, 60));
        if ($urandom_range(0, 9) == 0) begin reg_rd = 1; reg_addr = 4'($urandom_range(0, 2) & 2); end
        cyc("R1 rand");
      end else if (op < 62) begin
        wr(int'($urandom_range(4, 9)), int'($urandom_range(20, 40)), "R6 rand");
      end else if (op < 85) begin
        rd(int'($urandom_range(0, 10)), "R3 rand");
      end else if (op < 93) begin
        wr(3, 8'h04, "R4 rand");
      end else begin
        wr(1, int'($urandom_range(0, 63)), "R2 rand");
      end
    end
    failsafe_n = 1;
    rd(0, "R3 final"); rd(2, "R8 final");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule